// File: doc/BRIEF.md
# Oversampled Sample Regrouping Unit

This unit sits between a sample deserializer and a digital clock and data recovery core. The line is sampled at three samples per unit interval (UI), and the deserializer hands over a word of 32 three-bit codes on every clock. One such word covers ten and two-thirds UIs. Later phase and decision logic wants to work on whole UIs, so the unit repacks the stream into groups whose lengths are whole multiples of three samples.

The unit holds the few leftover samples of each word and adds them to the front of the next group. The result repeats every three accepted words: one group of 30 samples (10 UIs) and then two groups of 33 samples (11 UIs each). Every group leaves on a fixed 33-slot output. The short group is padded at its start with three dummy slots, which are driven to zero. A count goes with each group and gives the number of real slots, 30 or 33.

Each real code is also mapped to a symmetric signed value, 2*code-7, so that downstream sign and magnitude logic needs no offset. Idle cycles do not advance the pattern. A synchronous reset restarts it at the short group.

Top module: `regroup_unit`

## Requirements
- R1: While `rst` is sampled high at a rising edge, and on the cycle after that edge, `outValid` is 0 and `outCount` and `outGroup` are all zero.
- R2: Each real slot holds 2*code-7 as 4-bit two's complement. Code 0 gives 4'b1001 (-7) and code 7 gives 4'b0111 (+7), so every real slot value is odd.
- R3: `outValid` is 1 exactly in the cycle after a rising edge at which `inValid` was 1 and `rst` was 0. `outCount` and `outGroup` update at that same edge.
- R4: Over successive accepted words after reset, `outCount` runs 30, 33, 33 and then repeats.
- R5: For a 30-count group, slots 0..2 are zero. Slots 3..32 hold input samples 0..29 of the word just accepted. Slot k is `outGroup[4k+3:4k]` and input sample i is `inSamples[3i+2:3i]`. Slot 0 and sample 0 are the earliest in time.
- R6: For the 33-count group that follows a 30-count group, slots 0..1 hold samples 30 and 31 of the previous word, and slots 2..32 hold samples 0..30 of the current word.
- R7: For the second 33-count group, slot 0 holds sample 31 of the previous word, and slots 1..32 hold samples 0..31 of the current word. After this group no sample is left over.
- R8: A cycle with `inValid` low leaves the phase and the carried samples untouched. When input resumes, the stream continues exactly as if the idle cycles had never occurred.
- R9: A synchronous reset applied in the middle of the pattern drops any carried samples. The next accepted word then produces a 30-count group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | A new sample word is present |
| inSamples | input | 96 | 32 unsigned 3-bit codes, sample 0 in the low bits |
| outValid | output | 1 | Group output holds a new group |
| outCount | output | 6 | Number of real slots in the group: 30 or 33 |
| outGroup | output | 132 | 33 signed 4-bit slots, slot 0 in the low bits |

## Verification
Every result is due one clock after the word that causes it: the group, its count and `outValid` all come from a single register stage, and clearing carry and phase on reset also takes effect one edge later. The bench applies inputs just after a falling edge and compares the outputs at the next falling edge, against a queue-based model that steps once per clock with the inputs the design sampled at the rising edge in between. `outValid` is compared on every cycle. Count and slot contents are compared on every valid cycle, including those that follow idle gaps and a reset taken mid-pattern.

// File: rtl/regroup_pkg.sv
package regroup_pkg;

  localparam int SAMPLE_W    = 3;
  localparam int IN_SAMPLES  = 32;
  localparam int OSR         = 3;
  localparam int OUT_SLOTS   = 33;
  localparam int NUM_PHASES  = 3;
  localparam int VAL_W       = SAMPLE_W + 1;
  localparam int PHASE_W     = $clog2(NUM_PHASES);
  localparam int COUNT_W     = $clog2(OUT_SLOTS + 1);
  localparam int SHORT_COUNT = OUT_SLOTS - OSR;
  localparam int CARRY_MAX   = IN_SAMPLES - SHORT_COUNT;
  localparam int IN_W        = IN_SAMPLES * SAMPLE_W;
  localparam int GROUP_W     = OUT_SLOTS * VAL_W;
  localparam int CARRY_W     = CARRY_MAX * SAMPLE_W;
  localparam int CODE_MID    = (1 << SAMPLE_W) - 1;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic                  load;
    logic [NUM_PHASES-1:0] phaseSel;
  } ctrl_t;

  // Leading zero slots in the group of phase p
  function automatic int padSlots(input int p);
    return (p == 0) ? OSR : 0;
  endfunction

  // Samples held over from earlier words when phase p begins
  function automatic int carryEntering(input int p);
    return (p == 0) ? 0 : (p * IN_SAMPLES - SHORT_COUNT - (p - 1) * OUT_SLOTS);
  endfunction

  // Samples held over once phase p has emitted its group
  function automatic int carryLeaving(input int p);
    return carryEntering(p) + IN_SAMPLES - (OUT_SLOTS - padSlots(p));
  endfunction

  // Unsigned code to odd symmetric signed value: 2*code - (2^W - 1)
  function automatic logic [VAL_W-1:0] signedLevel(input logic [SAMPLE_W-1:0] code);
    return {code, 1'b0} - VAL_W'(CODE_MID);
  endfunction

endpackage

// File: rtl/regroup_ctrl.sv
module regroup_ctrl
  import regroup_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  inValid,
  output ctrl_t ctrl
);

  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(NUM_PHASES - 1);

  logic [PHASE_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
    end else if (inValid) begin
      phase <= (phase == LAST_PHASE) ? '0 : phase + 1'b1;
    end
  end

  logic [NUM_PHASES-1:0] phaseDec;

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_dec
    assign phaseDec[p] = (phase == PHASE_W'(p));
  end

  always_comb begin
    ctrl.load     = inValid;
    ctrl.phaseSel = phaseDec;
  end

  // R4
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    phase <= LAST_PHASE);

  // R4
  phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && phase == LAST_PHASE) |=> (phase == '0));

  // R8
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(phase));

  // R9
  phase_restart_chk: assert property (@(posedge clk)
    rst |=> (phase == '0));

endmodule

// File: rtl/regroup_datapath.sv
module regroup_datapath
  import regroup_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [IN_W-1:0]    inSamples,
  input  ctrl_t              ctrl,
  output logic               outValid,
  output logic [COUNT_W-1:0] outCount,
  output logic [GROUP_W-1:0] outGroup
);

  logic [CARRY_W-1:0] carryQ;

  logic [GROUP_W-1:0] candGroup [NUM_PHASES];
  logic [CARRY_W-1:0] candCarry [NUM_PHASES];

  // One candidate group and one leftover set per phase
  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
    localparam int PAD  = padSlots(p);
    localparam int HELD = carryEntering(p);
    localparam int LEFT = carryLeaving(p);

    for (genvar s = 0; s < OUT_SLOTS; s++) begin : g_slot
      if (s < PAD) begin : g_pad
        assign candGroup[p][s*VAL_W +: VAL_W] = '0;
      end else if (s - PAD < HELD) begin : g_held
        assign candGroup[p][s*VAL_W +: VAL_W] =
          signedLevel(carryQ[(s-PAD)*SAMPLE_W +: SAMPLE_W]);
      end else begin : g_new
        assign candGroup[p][s*VAL_W +: VAL_W] =
          signedLevel(inSamples[(s-PAD-HELD)*SAMPLE_W +: SAMPLE_W]);
      end
    end

    for (genvar j = 0; j < CARRY_MAX; j++) begin : g_left
      if (j < LEFT) begin : g_keep
        assign candCarry[p][j*SAMPLE_W +: SAMPLE_W] =
          inSamples[(IN_SAMPLES-LEFT+j)*SAMPLE_W +: SAMPLE_W];
      end else begin : g_none
        assign candCarry[p][j*SAMPLE_W +: SAMPLE_W] = '0;
      end
    end
  end

  logic [GROUP_W-1:0] selGroup;
  logic [CARRY_W-1:0] selCarry;
  logic [COUNT_W-1:0] selCount;

  always_comb begin
    selGroup = '0;
    selCarry = '0;
    selCount = '0;
    for (int p = 0; p < NUM_PHASES; p++) begin
      if (ctrl.phaseSel[p]) begin
        selGroup = selGroup | candGroup[p];
        selCarry = selCarry | candCarry[p];
        selCount = selCount | COUNT_W'(OUT_SLOTS - padSlots(p));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outCount <= '0;
      outGroup <= '0;
      carryQ   <= '0;
    end else begin
      outValid <= ctrl.load;
      if (ctrl.load) begin
        outGroup <= selGroup;
        outCount <= selCount;
        carryQ   <= selCarry;
      end
    end
  end

  // Every slot past the padding must carry an odd level
  logic realOdd;
  always_comb begin
    realOdd = 1'b1;
    for (int s = 0; s < OUT_SLOTS; s++) begin
      if (s >= OUT_SLOTS - int'(outCount)) realOdd = realOdd & outGroup[s*VAL_W];
    end
  end

  // R2
  real_slot_odd_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> realOdd);

  // R4
  count_legal_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outCount == COUNT_W'(SHORT_COUNT) || outCount == COUNT_W'(OUT_SLOTS)));

  // R5
  pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && outCount == COUNT_W'(SHORT_COUNT)) |-> (outGroup[OSR*VAL_W-1:0] == '0));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!outValid && outCount == '0 && outGroup == '0));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl.load |=> ($stable(outGroup) && $stable(outCount)));

endmodule

// File: rtl/regroup_unit.sv
module regroup_unit
  import regroup_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [IN_W-1:0]    inSamples,
  output logic               outValid,
  output logic [COUNT_W-1:0] outCount,
  output logic [GROUP_W-1:0] outGroup
);

  ctrl_t ctrl;

  regroup_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .ctrl    (ctrl)
  );

  regroup_datapath u_data (
    .clk       (clk),
    .rst       (rst),
    .inSamples (inSamples),
    .ctrl      (ctrl),
    .outValid  (outValid),
    .outCount  (outCount),
    .outGroup  (outGroup)
  );

  // R3
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  // R3
  valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

endmodule

// File: tb/regroup_unit_test.sv
module regroup_unit_test;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [95:0]  inSamples = '0;
  logic         outValid;
  logic [5:0]   outCount;
  logic [131:0] outGroup;

  always #4 clk = ~clk;

  regroup_unit uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inSamples(inSamples),
    .outValid(outValid), .outCount(outCount), .outGroup(outGroup)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference model state
  int           q[$];
  int           mPhase = 0;
  bit           eValid = 0;
  int           eCount = 0;
  logic [131:0] eGroup = '0;
  string        eTag = "R1";
  bit           sawIdle = 0;
  bit           anyWord = 0;
  bit           midReset = 0;

  // Inputs the design sampled at the last rising edge
  bit           pRst = 1;
  bit           pValid = 0;
  logic [95:0]  pWord = '0;

  task automatic check(input bit ok, input string tag, input logic [131:0] act,
                       input logic [131:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelStep();
    if (pRst) begin
      q.delete();
      mPhase = 0;
      eValid = 0;
      eCount = 0;
      eGroup = '0;
      if (anyWord) midReset = 1;
      eTag = midReset ? "R9" : "R1";
      sawIdle = 0;
    end else if (pValid) begin
      int n;
      int pad;
      for (int i = 0; i < 32; i++) q.push_back(int'(pWord[3*i +: 3]));
      n   = (mPhase == 0) ? 30 : 33;
      pad = 33 - n;
      eGroup = '0;
      for (int s = pad; s < 33; s++) begin
        int c;
        c = q.pop_front();
        eGroup[4*s +: 4] = 4'(2 * c - 7);
      end
      if (midReset)     eTag = "R9 R2";
      else if (sawIdle) eTag = "R8 R2";
      else if (mPhase == 0) eTag = "R5 R2";
      else if (mPhase == 1) eTag = "R6 R2";
      else                  eTag = "R7 R2";
      eValid = 1;
      eCount = n;
      mPhase = (mPhase + 1) % 3;
      anyWord = 1;
      midReset = 0;
      sawIdle = 0;
    end else begin
      eValid = 0;
      if (anyWord) sawIdle = 1;
    end
  endtask

  task automatic step(input bit r, input bit v, input logic [95:0] w);
    @(negedge clk);
    modelStep();
    check(outValid == eValid, (eTag == "R1") ? "R1 valid" : "R3 valid",
          132'(outValid), 132'(eValid));
    if (!eValid) begin
      if (pRst) begin
        check(outCount == 6'd0 && outGroup == '0, eTag, outGroup, '0);
      end
    end else begin
      check(int'(outCount) == eCount, "R4 count", 132'(outCount), 132'(eCount));
      check(outGroup == eGroup, eTag, outGroup, eGroup);
    end
    rst = r; inValid = v; inSamples = w;
    pRst = r; pValid = v; pWord = w;
  endtask

  function automatic logic [95:0] rampWord(input int base);
    logic [95:0] w;
    for (int i = 0; i < 32; i++) w[3*i +: 3] = 3'((base + i) % 8);
    return w;
  endfunction

  function automatic logic [95:0] fillWord(input int code);
    logic [95:0] w;
    for (int i = 0; i < 32; i++) w[3*i +: 3] = 3'(code);
    return w;
  endfunction

  function automatic logic [95:0] randWord();
    return {$urandom(), $urandom(), $urandom()};
  endfunction

  initial begin
    // Reset held, checked on the cycle after each reset edge (R1)
    repeat (3) step(1, 0, '0);
    step(0, 0, '0);
    step(0, 0, '0);
    // Continuous ramps: three full 30/33/33 rounds (R4 R5 R6 R7)
    for (int k = 0; k < 9; k++) step(0, 1, rampWord(k * 5));
    // Extreme codes (R2)
    step(0, 1, fillWord(0));
    step(0, 1, fillWord(7));
    step(0, 1, fillWord(3));
    step(0, 1, fillWord(4));
    // Idle gaps inside the pattern (R8)
    step(0, 0, randWord());
    step(0, 1, rampWord(1));
    step(0, 0, randWord());
    step(0, 0, randWord());
    step(0, 1, rampWord(2));
    step(0, 1, rampWord(3));
    step(0, 0, randWord());
    step(0, 1, rampWord(4));
    // Reset in the middle of the pattern (R9)
    step(0, 1, randWord());
    step(1, 1, randWord());
    step(0, 1, rampWord(6));
    step(0, 1, rampWord(7));
    step(1, 0, '0);
    step(0, 1, randWord());
    step(0, 1, randWord());
    // Random traffic
    for (int k = 0; k < 300; k++) step(0, ($urandom() % 4) != 0, randWord());
    step(0, 0, '0);
    step(0, 0, '0);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule